// File: doc/BRIEF.md
# Packed Saturating Lane Adder

This block adds or subtracts two 64-bit words that are split into independent lanes, so that every lane of a word is computed in a single operation. The lane width is picked per request: eight lanes of 8 bits, four of 16 bits or two of 32 bits. Each operation either wraps modulo the lane size or clamps each lane to its own limits, and clamping can treat lanes as unsigned or as two's-complement signed. Carries and borrows never pass from one lane into the next.

Operands come from an eight-entry file of 64-bit registers. The result goes back into the file, and it is also shown on a result port together with a per-lane clamp report. A request has an opcode, a lane-size code, two source indices and a destination index, and it is taken on a valid/ready handshake. A separate load port places words into the file. The handshake is run by a two-state controller. In IDLE the unit accepts a request. IDLE moves to WBACK on an accepted request and stays in IDLE otherwise. In WBACK the registered result is written back and reported. WBACK always returns to IDLE on the next cycle.

Top module: `psimd_unit`

## Requirements
- R1: After reset, every register holds zero, `req_ready` is high and `res_valid` is low.
- R2: A load (`ld_en` high) in a cycle with `req_ready` high writes `ld_data` into register `ld_idx`. A load in a cycle with `req_ready` low is ignored, so the write-back result stays in place and other registers keep their old values.
- R3: `req_ready` is high exactly in IDLE. A request taken at an edge raises `res_valid` for exactly the next cycle, and `req_ready` is low in that cycle.
- R4: During the `res_valid` cycle, `res_data` holds the result. That result is in register `req_dst` at the end of that cycle, so a request accepted on the following cycle reads the new value.
- R5: `req_lsz` encodes 0 = 8-bit lanes, 1 = 16-bit lanes, 2 or 3 = 32-bit lanes. Lane i occupies bits [i*n+n-1 : i*n], and no carry or borrow crosses a lane boundary in any mode.
- R6: Opcode 0 adds and opcode 1 subtracts (A minus B), both modulo 2^n per lane. Opcodes 6 and 7 behave as opcode 0.
- R7: Opcode 2 adds and opcode 3 subtracts with unsigned clamping. A lane result above 2^n-1 becomes 2^n-1, and a lane result below 0 becomes 0.
- R8: Opcode 4 adds and opcode 5 subtracts with signed clamping. A lane result above 2^(n-1)-1 becomes 2^(n-1)-1, and a lane result below -2^(n-1) becomes -2^(n-1).
- R9: `sat_flags` bit i is high during `res_valid` exactly when lane i was clamped. All bits are zero for opcodes 0, 1, 6 and 7, and bits at and above the lane count are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ld_en | input | 1 | Load strobe for the register file |
| ld_idx | input | 3 | Register written by a load |
| ld_data | input | 64 | Word written by a load |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_op | input | 3 | Operation code (see R6 to R8) |
| req_lsz | input | 2 | Lane size code (see R5) |
| req_src_a | input | 3 | First operand register |
| req_src_b | input | 3 | Second operand register |
| req_dst | input | 3 | Destination register |
| res_valid | output | 1 | Result cycle strobe |
| res_data | output | 64 | Result word |
| sat_flags | output | 8 | Per-lane clamp report |

## Verification
A wrong clamp limit or a carry leaking across a lane boundary shows on `res_data` and `sat_flags` in the same cycle as `res_valid`, one cycle after the request is taken. A bad write-back, or a load that is not dropped, is silent when it happens. It shows at the ports on the next operation that reads that register, which the bench issues on the very next cycle. A controller stuck in the wrong state shows at once as `req_ready` and `res_valid` out of step with the requests.

// File: rtl/psimd_pkg.sv
package psimd_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_ADDUS = 3'd2,
        OP_SUBUS = 3'd3,
        OP_ADDSS = 3'd4,
        OP_SUBSS = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WBACK = 1'b1
    } st_e;

    typedef struct packed {
        logic sub;
        logic sat;
        logic sgn;
    } opdec_t;

    function automatic opdec_t decode_op(input logic [2:0] op);
        opdec_t d;
        d = '0;
        unique case (op_e'(op))
            OP_ADD, OP_RSV6, OP_RSV7: d = '0;
            OP_SUB:   d.sub = 1'b1;
            OP_ADDUS: d.sat = 1'b1;
            OP_SUBUS: begin d.sub = 1'b1; d.sat = 1'b1; end
            OP_ADDSS: begin d.sat = 1'b1; d.sgn = 1'b1; end
            OP_SUBSS: begin d.sub = 1'b1; d.sat = 1'b1; d.sgn = 1'b1; end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/psimd_regfile.sv
module psimd_regfile #(
    parameter int DATA_W = 64,
    parameter int NREGS  = 8,
    localparam int IW    = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IW-1:0]     rd_a_idx,
    input  logic [IW-1:0]     rd_b_idx,
    output logic [DATA_W-1:0] rd_a,
    output logic [DATA_W-1:0] rd_b,
    input  logic              we,
    input  logic [IW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] mem [NREGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_a = mem[rd_a_idx];
    assign rd_b = mem[rd_b_idx];

    // R4: a written word is held by its register on the next cycle
    a_r4_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/psimd_lanes.sv
module psimd_lanes
    import psimd_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8,
    localparam int NL    = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  opdec_t            dec,
    output logic [DATA_W-1:0] res,
    output logic [NL-1:0]     clamp
);

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic [LANE_W-1:0] la, lb, bx, lr;
        logic [LANE_W:0]   ext;
        logic              ovf_u, ovf_s, hit;

        assign la  = a[i*LANE_W +: LANE_W];
        assign lb  = b[i*LANE_W +: LANE_W];
        assign bx  = dec.sub ? ~lb : lb;
        assign ext = {1'b0, la} + {1'b0, bx} + {{LANE_W{1'b0}}, dec.sub};
        // carry out on add, or no carry (borrow) on subtract
        assign ovf_u = ext[LANE_W] ^ dec.sub;
        assign ovf_s = (la[LANE_W-1] == bx[LANE_W-1]) && (ext[LANE_W-1] != la[LANE_W-1]);

        always_comb begin
            hit = 1'b0;
            lr  = ext[LANE_W-1:0];
            if (dec.sat) begin
                if (!dec.sgn && ovf_u) begin
                    hit = 1'b1;
                    lr  = dec.sub ? {LANE_W{1'b0}} : {LANE_W{1'b1}};
                end else if (dec.sgn && ovf_s) begin
                    hit = 1'b1;
                    lr  = la[LANE_W-1] ? {1'b1, {(LANE_W-1){1'b0}}}
                                       : {1'b0, {(LANE_W-1){1'b1}}};
                end
            end
        end

        assign res[i*LANE_W +: LANE_W] = lr;
        assign clamp[i] = hit;
    end

endmodule

// File: rtl/psimd_ctrl.sv
module psimd_ctrl
    import psimd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    output logic req_ready,
    output logic accept,
    output logic wb_en
);

    st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_WBACK;
            ST_WBACK: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        wb_en     = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_WBACK: wb_en     = 1'b1;
        endcase
        accept = req_ready && req_valid;
    end

    // R3: write-back always follows an accepted request
    a_r3_accept_then_wb: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> wb_en);
    // R3: write-back lasts one cycle
    a_r3_wb_single: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> !wb_en);

endmodule

// File: rtl/psimd_unit.sv
module psimd_unit
    import psimd_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int NREGS  = 8,
    localparam int IW    = $clog2(NREGS),
    localparam int MAXL  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [IW-1:0]     ld_idx,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [1:0]        req_lsz,
    input  logic [IW-1:0]     req_src_a,
    input  logic [IW-1:0]     req_src_b,
    input  logic [IW-1:0]     req_dst,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic [MAXL-1:0]   sat_flags
);

    localparam int NSIZES = 3;

    logic              accept, wb_en;
    logic [DATA_W-1:0] opa, opb;
    logic              we;
    logic [IW-1:0]     wr_idx;
    logic [DATA_W-1:0] wr_data;
    opdec_t            dec;
    logic [1:0]        sel;

    logic [DATA_W-1:0] res_k [NSIZES];
    logic [MAXL-1:0]   flg_k [NSIZES];

    logic [DATA_W-1:0] rslt_q;
    logic [MAXL-1:0]   flags_q;
    logic [IW-1:0]     dst_q;
    logic [1:0]        sel_q;
    logic              sat_q;

    psimd_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .accept    (accept),
        .wb_en     (wb_en)
    );

    // write-back owns the port; a load is dropped in that cycle
    assign we      = wb_en || ld_en;
    assign wr_idx  = wb_en ? dst_q  : ld_idx;
    assign wr_data = wb_en ? rslt_q : ld_data;

    psimd_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (req_src_a),
        .rd_b_idx (req_src_b),
        .rd_a     (opa),
        .rd_b     (opb),
        .we       (we),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data)
    );

    assign dec = decode_op(req_op);
    assign sel = (req_lsz == 2'd0) ? 2'd0 : (req_lsz == 2'd1) ? 2'd1 : 2'd2;

    for (genvar k = 0; k < NSIZES; k++) begin : g_size
        localparam int LW = 8 << k;
        localparam int NL = DATA_W / LW;
        logic [NL-1:0] clamp;

        psimd_lanes #(.DATA_W(DATA_W), .LANE_W(LW)) u_lanes (
            .a     (opa),
            .b     (opb),
            .dec   (dec),
            .res   (res_k[k]),
            .clamp (clamp)
        );
        assign flg_k[k] = MAXL'(clamp);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rslt_q  <= '0;
            flags_q <= '0;
            dst_q   <= '0;
            sel_q   <= '0;
            sat_q   <= 1'b0;
        end else if (accept) begin
            rslt_q  <= res_k[sel];
            flags_q <= flg_k[sel];
            dst_q   <= req_dst;
            sel_q   <= sel;
            sat_q   <= dec.sat;
        end
    end

    assign res_valid = wb_en;
    assign res_data  = rslt_q;
    assign sat_flags = wb_en ? flags_q : '0;

    // R3: no request is taken while a result is reported
    a_r3_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !req_ready);
    // R3: a taken request is reported on the next cycle
    a_r3_result_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> res_valid);
    // R9: wrapping operations never report a clamp
    a_r9_wrap_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !sat_q) |-> (sat_flags == '0));
    // R9: 32-bit lanes use only the two low flag bits
    a_r9_wide_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && sel_q == 2'd2) |-> (sat_flags[MAXL-1:2] == '0));
    // R9: flags are quiet outside the result cycle
    a_r9_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (sat_flags == '0));

endmodule

// File: tb/psimd_unit_test.sv
module psimd_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_idx = '0;
    logic [63:0] ld_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = '0;
    logic [1:0]  req_lsz = '0;
    logic [2:0]  req_src_a = '0, req_src_b = '0, req_dst = '0;
    logic        res_valid;
    logic [63:0] res_data;
    logic [7:0]  sat_flags;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] mreg [8];

    always #4 clk = ~clk;

    psimd_unit uut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_lsz(req_lsz),
        .req_src_a(req_src_a), .req_src_b(req_src_b), .req_dst(req_dst),
        .res_valid(res_valid), .res_data(res_data), .sat_flags(sat_flags)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input int op, input int ls, input logic [63:0] a,
                                          input logic [63:0] b, output logic [7:0] fl);
        int n, nl, kind;
        bit sub;
        longint one, ua, ub, sa, sb, r, lo, hi;
        logic [63:0] mask, out;
        one  = 1;
        n    = (ls == 0) ? 8 : (ls == 1) ? 16 : 32;
        nl   = 64 / n;
        sub  = (op == 1 || op == 3 || op == 5);
        kind = (op == 2 || op == 3) ? 1 : (op == 4 || op == 5) ? 2 : 0;
        mask = (64'd1 << n) - 64'd1;
        out  = '0;
        fl   = '0;
        for (int i = 0; i < nl; i++) begin
            ua = longint'((a >> (i * n)) & mask);
            ub = longint'((b >> (i * n)) & mask);
            sa = (ua >= (one << (n - 1))) ? ua - (one << n) : ua;
            sb = (ub >= (one << (n - 1))) ? ub - (one << n) : ub;
            if (kind == 2) begin
                r  = sub ? sa - sb : sa + sb;
                lo = -(one << (n - 1));
                hi = (one << (n - 1)) - 1;
            end else begin
                r  = sub ? ua - ub : ua + ub;
                lo = 0;
                hi = (one << n) - 1;
            end
            if (kind != 0 && r > hi) begin r = hi; fl[i] = 1'b1; end
            if (kind != 0 && r < lo) begin r = lo; fl[i] = 1'b1; end
            out = out | ((64'(r) & mask) << (i * n));
        end
        return out;
    endfunction

    function automatic string op_tag(input int op);
        if (op == 2 || op == 3) return "R7";
        if (op == 4 || op == 5) return "R8";
        return "R6";
    endfunction

    task automatic load(input int idx, input logic [63:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = 3'(idx); ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
        mreg[idx] = d;
    endtask

    task automatic do_op(input int op, input int ls, input int sa, input int sb, input int dst,
                         input string tag);
        logic [63:0] exp;
        logic [7:0]  efl;
        @(negedge clk);
        chk(req_ready == 1'b1 && res_valid == 1'b0, "R3 idle", {62'd0, req_ready, res_valid}, 64'd2);
        req_valid = 1'b1; req_op = 3'(op); req_lsz = 2'(ls);
        req_src_a = 3'(sa); req_src_b = 3'(sb); req_dst = 3'(dst);
        exp = model(op, ls, mreg[sa], mreg[sb], efl);
        @(negedge clk);
        req_valid = 1'b0;
        chk(res_valid == 1'b1 && req_ready == 1'b0, "R3 result cycle", {62'd0, req_ready, res_valid}, 64'd1);
        chk(res_data == exp, tag, res_data, exp);
        chk(sat_flags == efl, "R9 flags", {56'd0, sat_flags}, {56'd0, efl});
        mreg[dst] = exp;
    endtask

    // reads a register through an add with register 7, which stays zero
    task automatic peek(input int idx, input string tag);
        do_op(0, 0, idx, 7, idx, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 8; i++) mreg[i] = '0;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && res_valid == 1'b0, "R1 reset outputs", {62'd0, req_ready, res_valid}, 64'd2);
        rst_n = 1'b1;
        for (int i = 0; i < 7; i++) peek(i, "R1 register zero");

        // R5 R6: per-lane wrap with no carry across lanes
        load(0, 64'hFFFF_FFFF_FFFF_FFFF);
        load(1, 64'h0000_0000_0000_0001);
        do_op(0, 0, 0, 1, 2, "R5 byte wrap");
        do_op(0, 1, 0, 1, 2, "R5 half wrap");
        do_op(0, 2, 0, 1, 2, "R5 word wrap");
        do_op(0, 3, 0, 1, 2, "R5 code 3 word");
        do_op(1, 0, 1, 0, 2, "R6 byte sub wrap");
        do_op(6, 0, 0, 1, 2, "R6 opcode 6");
        do_op(7, 1, 0, 1, 2, "R6 opcode 7");
        // R7 unsigned clamp
        do_op(2, 0, 0, 1, 3, "R7 add max");
        do_op(3, 1, 1, 0, 3, "R7 sub min");
        // R8 signed clamp
        load(4, 64'h7F80_7FFF_8000_7F80);
        load(5, 64'h0101_0001_0001_0101);
        do_op(4, 0, 4, 5, 6, "R8 byte add");
        do_op(5, 0, 4, 5, 6, "R8 byte sub");
        do_op(4, 1, 4, 5, 6, "R8 half add");
        do_op(5, 2, 4, 5, 6, "R8 word sub");
        // R4: back-to-back dependent operations
        do_op(0, 0, 5, 5, 3, "R4 produce");
        do_op(0, 0, 3, 3, 3, "R4 consume");

        // R2: load during write-back is dropped
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd0; req_lsz = 2'd0;
        req_src_a = 3'd5; req_src_b = 3'd5; req_dst = 3'd6;
        @(negedge clk);
        req_valid = 1'b0;
        ld_en = 1'b1; ld_idx = 3'd6; ld_data = 64'hDEAD_BEEF_0000_1111;
        @(negedge clk);
        ld_en = 1'b1; ld_idx = 3'd1; ld_data = 64'h1234_5678_9ABC_DEF0;
        @(negedge clk);
        ld_en = 1'b0;
        mreg[6] = 64'h0202_0002_0002_0202;
        mreg[1] = 64'h1234_5678_9ABC_DEF0;
        peek(6, "R2 write-back wins");
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd0; req_lsz = 2'd0;
        req_src_a = 3'd7; req_src_b = 3'd7; req_dst = 3'd2;
        @(negedge clk);
        req_valid = 1'b0;
        ld_en = 1'b1; ld_idx = 3'd4; ld_data = 64'hAAAA_AAAA_AAAA_AAAA;
        @(negedge clk);
        ld_en = 1'b0;
        mreg[2] = '0;
        peek(4, "R2 other register untouched");
        peek(1, "R2 idle load");

        // random mix
        for (int t = 0; t < 400; t++) begin
            int op, ls;
            if ($urandom_range(0, 3) == 0)
                load($urandom_range(0, 6), {$urandom, $urandom});
            op = $urandom_range(0, 7);
            ls = $urandom_range(0, 3);
            do_op(op, ls, $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 6), op_tag(op));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule